// File: doc/BRIEF.md
# Operand Addressing and Pointer Unit

This block is the data-memory operand path of a small 8-bit accumulator machine. It holds an accumulator and two pointer registers, B and X. The instruction sequencer hands it a decoded operation, an addressing mode and the instruction byte that goes with them, and pulses `start_i`. The block then forms the data-memory address or picks up the immediate operand, performs the access on a synchronous RAM port, and updates its registers. It can load the accumulator, swap the accumulator with a memory byte, and load B with a short 4-bit immediate.

An indirect access can step its pointer by one in either direction. The step happens after the access, so the access itself uses the pointer value from before the step. `done_o` pulses for one clock once every register and memory update has settled. `start_i` is sampled only while the block is idle.

Top module: `opnd_addr_unit`

## Requirements
- R1: While `rst_ni` is low, the accumulator, B and X read zero and `done_o` is low.
- R2: Direct mode (mode 0) uses `operand_i` as the full 8-bit data-memory address.
- R3: Indirect modes take the address from B (mode 1) or from X (mode 2). The other pointer is not touched.
- R4: Mode 3 is B with post-increment, mode 4 is B with post-decrement, mode 5 is X with post-increment and mode 6 is X with post-decrement. The access uses the old pointer value. Afterwards the pointer steps by one, wrapping modulo 256.
- R5: Load accumulator (op 0) with immediate mode (mode 7) copies `operand_i` into the accumulator and writes no memory.
- R6: Short load of B (op 2, mode 7) sets B to `{4'b0000, operand_i[3:0]}`.
- R7: Exchange (op 1, modes 0 to 6) reads the addressed byte and, in the following cycle, writes the old accumulator to the same address. The accumulator then holds the old memory byte.
- R8: Load accumulator (op 0, modes 0 to 6) copies the addressed memory byte into the accumulator and writes no memory.
- R9: `done_o` is a one-cycle pulse. For a memory operation it is high in the third cycle after the start edge. For an immediate, short or unsupported operation it is high in the first cycle after the start edge.
- R10: Op 3, exchange with mode 7, and op 2 with any mode other than 7 are unsupported. They change no register, write no memory and still give `done_o`.
- R11: `start_i` is ignored from the accepting edge until the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; sampled while idle |
| op_i | input | 2 | Operation: 0 load acc, 1 exchange, 2 short load B, 3 unsupported |
| mode_i | input | 3 | Addressing mode, encoded 0 to 7 as listed in R2 to R5 |
| operand_i | input | 8 | Instruction byte: address, immediate or short value |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 8 | Data-memory address |
| mem_wdata_o | output | 8 | Data-memory write data |
| mem_we_o | output | 1 | Data-memory write enable |
| mem_rdata_i | input | 8 | Data-memory read data, valid one cycle after the address |
| acc_o | output | 8 | Accumulator |
| b_o | output | 8 | Pointer B |
| x_o | output | 8 | Pointer X |

## Verification
The assertions assume that the RAM returns, one cycle after it samples an address, the byte stored at that address. The bench's behavioural RAM has exactly this registered-read behaviour. The assertions also assume that `start_i` may be asserted at any time. The bench deliberately holds `start_i` high, with altered op and mode values, throughout several busy periods, so that a transaction accepted while busy would show up. Every op and mode pair is swept with varied operand bytes, including the pointer wrap at 0 and 255.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  typedef enum logic [1:0] {OP_LDA = 2'd0, OP_XCH = 2'd1, OP_LDB_S = 2'd2, OP_RSV = 2'd3} op_e;

  typedef enum logic [2:0] {
    M_DIR   = 3'd0,
    M_IND_B = 3'd1,
    M_IND_X = 3'd2,
    M_B_INC = 3'd3,
    M_B_DEC = 3'd4,
    M_X_INC = 3'd5,
    M_X_DEC = 3'd6,
    M_IMM   = 3'd7
  } mode_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_CAP, ST_DONE} st_e;

  typedef struct packed {
    logic valid;
    logic mem;
    logic xch;
    logic ld_b;
    logic use_x;
    logic ptr_upd;
    logic ptr_dec;
  } dec_t;
endpackage

// File: rtl/opnd_decode.sv
module opnd_decode
  import opnd_pkg::*;
(
  input  logic [1:0] op_i,
  input  logic [2:0] mode_i,
  output dec_t       dec_o
);
  mode_e mode;
  assign mode = mode_e'(mode_i);

  always_comb begin
    dec_o = '0;
    unique case (op_e'(op_i))
      OP_LDA:   dec_o.valid = 1'b1;
      OP_XCH: begin
        dec_o.valid = (mode != M_IMM);
        dec_o.xch   = (mode != M_IMM);
      end
      OP_LDB_S: begin
        dec_o.valid = (mode == M_IMM);
        dec_o.ld_b  = (mode == M_IMM);
      end
      default:  dec_o = '0;
    endcase
    dec_o.mem     = dec_o.valid && !dec_o.ld_b && (mode != M_IMM);
    dec_o.use_x   = (mode == M_IND_X) || (mode == M_X_INC) || (mode == M_X_DEC);
    dec_o.ptr_dec = (mode == M_B_DEC) || (mode == M_X_DEC);
    dec_o.ptr_upd = dec_o.mem && (mode inside {M_B_INC, M_B_DEC, M_X_INC, M_X_DEC});
  end
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
  parameter int unsigned W = 8
) (
  input  logic         dir_i,
  input  logic         use_x_i,
  input  logic         dec_i,
  input  logic [W-1:0] operand_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] ptr_next_o
);
  logic [W-1:0] ptr;

  assign ptr        = use_x_i ? x_i : b_i;
  assign addr_o     = dir_i ? operand_i : ptr;
  // modulo-2^W step of the selected pointer
  assign ptr_next_o = dec_i ? ptr - W'(1) : ptr + W'(1);
endmodule

// File: rtl/opnd_ctrl.sv
module opnd_ctrl
  import opnd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mem_op_i,
  output st_e  st_o,
  output logic accept_o
);
  st_e st_q, st_d;

  assign accept_o = (st_q == ST_IDLE) && start_i;
  assign st_o     = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = mem_op_i ? ST_RD : ST_DONE;
      ST_RD:   st_d = ST_CAP;
      ST_CAP:  st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import opnd_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SHORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [2:0]        mode_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              done_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] x_o
);
  localparam int unsigned AW = DATA_W;  // pointers hold full addresses

  st_e             st;
  logic            accept;
  dec_t            dec_d;
  logic [AW-1:0]   addr_d, addr_q, ptr_d, ptr_q;
  logic            xch_q, upd_q, use_x_q;
  logic [DATA_W-1:0] acc_q, b_q, x_q;

  opnd_decode u_dec (
    .op_i   (op_i),
    .mode_i (mode_i),
    .dec_o  (dec_d)
  );

  opnd_addr_gen #(.W(AW)) u_agen (
    .dir_i      (mode_e'(mode_i) == M_DIR),
    .use_x_i    (dec_d.use_x),
    .dec_i      (dec_d.ptr_dec),
    .operand_i  (operand_i),
    .b_i        (b_q),
    .x_i        (x_q),
    .addr_o     (addr_d),
    .ptr_next_o (ptr_d)
  );

  opnd_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mem_op_i (dec_d.mem),
    .st_o     (st),
    .accept_o (accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      b_q     <= '0;
      x_q     <= '0;
      addr_q  <= '0;
      ptr_q   <= '0;
      xch_q   <= 1'b0;
      upd_q   <= 1'b0;
      use_x_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= addr_d;
        ptr_q   <= ptr_d;
        xch_q   <= dec_d.xch;
        upd_q   <= dec_d.ptr_upd;
        use_x_q <= dec_d.use_x;
        if (dec_d.valid && !dec_d.mem) begin
          if (dec_d.ld_b) b_q   <= DATA_W'(operand_i[SHORT_W-1:0]);
          else            acc_q <= operand_i;
        end
      end
      if (st == ST_CAP) begin
        acc_q <= mem_rdata_i;
        if (upd_q) begin
          if (use_x_q) x_q <= ptr_q;
          else         b_q <= ptr_q;
        end
      end
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = acc_q;
  assign mem_we_o    = (st == ST_CAP) && xch_q;
  assign done_o      = (st == ST_DONE);
  assign acc_o       = acc_q;
  assign b_o         = b_q;
  assign x_o         = x_q;
endmodule

// File: rtl/opnd_addr_unit_chk.sv
module opnd_addr_unit_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic [DATA_W-1:0] acc_o,
  input logic [DATA_W-1:0] b_o,
  input logic [DATA_W-1:0] x_o
);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_we_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  p_we_then_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> done_o);

  p_we_same_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $stable(mem_addr_o));

  p_xch_acc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> acc_o == $past(mem_rdata_i));

  p_quiet_after_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(acc_o) && $stable(b_o) && $stable(x_o));
endmodule

bind opnd_addr_unit opnd_addr_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rdata_i (mem_rdata_i),
  .acc_o       (acc_o),
  .b_o         (b_o),
  .x_o         (x_o)
);

// File: tb/test_opnd_addr_unit.sv
`timescale 1ns/1ps
module test_opnd_addr_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] op_i = '0;
  logic [2:0] mode_i = '0;
  logic [7:0] operand_i = '0;
  logic       done_o, mem_we_o;
  logic [7:0] mem_addr_o, mem_wdata_o, mem_rdata_i, acc_o, b_o, x_o;

  logic [7:0] ram [256];
  logic [7:0] mdl [256];
  logic [7:0] m_acc = '0, m_b = '0, m_x = '0;
  int errs = 0, checks = 0, wr_total = 0;
  logic [7:0] last_wr_addr = '0;

  always #2.5 clk_i = ~clk_i;

  opnd_addr_unit i_opnd_addr_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i), .mode_i(mode_i),
    .operand_i(operand_i), .done_o(done_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .mem_rdata_i(mem_rdata_i),
    .acc_o(acc_o), .b_o(b_o), .x_o(x_o)
  );

  // registered-read RAM
  always @(posedge clk_i) begin
    mem_rdata_i <= ram[mem_addr_o];
    if (mem_we_o) begin
      ram[mem_addr_o] <= mem_wdata_o;
      wr_total        <= wr_total + 1;
      last_wr_addr    <= mem_addr_o;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input int op, input int mode, input int opnd, input bit hold);
    bit valid, mem, xch;
    int addr, exp_lat, lat, w0;
    string tag, ptag;
    logic [7:0] tmp;
    valid = (op == 0) || (op == 1 && mode != 7) || (op == 2 && mode == 7);
    mem   = valid && op != 2 && mode != 7;
    xch   = valid && op == 1;
    addr  = (mode == 0) ? opnd : (mode inside {2, 5, 6}) ? int'(m_x) : int'(m_b);
    if (!valid)                 tag = "R10";
    else if (op == 2)           tag = "R6";
    else if (op == 1)           tag = "R7";
    else if (mode == 7)         tag = "R5";
    else if (mode == 0)         tag = "R2";
    else if (mode inside {1,2}) tag = "R3";
    else                        tag = "R8";
    ptag = (mem && mode inside {3, 4, 5, 6}) ? "R4" : (mem && mode inside {1, 2}) ? "R3" : tag;
    // model
    if (valid) begin
      if (op == 2) m_b = {4'b0000, opnd[3:0]};
      else if (!mem) m_acc = opnd[7:0];
      else begin
        tmp = mdl[addr];
        if (xch) mdl[addr] = m_acc;
        m_acc = tmp;
        case (mode)
          3: m_b = m_b + 8'd1;
          4: m_b = m_b - 8'd1;
          5: m_x = m_x + 8'd1;
          6: m_x = m_x - 8'd1;
          default: ;
        endcase
      end
    end
    exp_lat = mem ? 3 : 1;
    w0 = wr_total;
    @(negedge clk_i);
    start_i = 1'b1; op_i = op[1:0]; mode_i = mode[2:0]; operand_i = opnd[7:0];
    lat = 99;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk_i);
      if (!hold) start_i = 1'b0;
      else begin op_i = 2'd2; mode_i = 3'd7; operand_i = 8'hFF; end  // R11 would change B
      if (done_o) begin lat = c; break; end
    end
    start_i = 1'b0;
    chk(hold ? "R11 latency" : "R9 latency", lat, exp_lat);
    chk({tag, " acc"}, acc_o, m_acc);
    chk({ptag, " B"}, b_o, m_b);
    chk({ptag, " X"}, x_o, m_x);
    chk({tag, " writes"}, wr_total - w0, xch ? 1 : 0);
    if (mem) chk({tag, " mem"}, ram[addr], mdl[addr]);
    if (xch) chk("R7 write addr", last_wr_addr, addr);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'(i * 37 + 5);
      mdl[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk_i);
    chk("R1 acc", acc_o, 0);
    chk("R1 B", b_o, 0);
    chk("R1 X", x_o, 0);
    chk("R1 done", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 done after release", done_o, 0);

    // full sweep over op and mode
    for (int op = 0; op < 4; op++)
      for (int mode = 0; mode < 8; mode++)
        for (int k = 0; k < 8; k++)
          do_op(op, mode, (k * 53 + 11) % 256, 1'b0);

    // pointer wrap at both ends
    do_op(2, 7, 8'hF0, 1'b0);   // B = 00, high nibble cleared
    do_op(0, 4, 0, 1'b0);       // [B-] from 00 -> FF
    do_op(1, 3, 0, 1'b0);       // [B+] from FF -> 00
    for (int i = 0; i < 260; i++) do_op(0, 6, 0, 1'b0);  // X walks down through wrap
    do_op(1, 5, 0, 1'b0);

    // start held high while busy
    do_op(0, 7, 8'h3C, 1'b1);
    do_op(1, 1, 0, 1'b1);
    do_op(0, 5, 0, 1'b1);
    do_op(3, 2, 0, 1'b1);
    do_op(2, 0, 8'h55, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule